// File: doc/BRIEF.md
# Per-Lane Data Eye Centering Trainer

This block finds, for every data bit lane, the delay tap at which read-back data sits in the middle of its valid window. A training run starts with one pulse on `start`. The trainer first writes a mode register so that reads and writes reach a small bank of pattern registers instead of the memory array. It then steps one shared sweep tap from 0 to the last tap. At each tap it writes the four pattern registers, reads them back, moves to the next tap, and scores the tap it just left.

Each lane records its first and last passing tap. When the sweep ends, the lane loads the rounded-down midpoint of those two taps. A lane that never passes, or whose passing taps have a gap, raises a failure flag and keeps its earlier tap. The analog delay lines and the memory sit outside the block. The trainer only drives the tap selects and a request stream, and it takes in a response stream.

Both streams use valid/ready. A request stays on the bus, unchanged, until `req_ready` is seen high at a clock edge. The trainer keeps at most one read outstanding and raises `rsp_ready` only while it waits for that read. The downstream side may stall either stream for any number of cycles.

Top module: `eye_trainer`

## Requirements
- R1: After reset, `busy`, `done` and `req_valid` are 0, every lane's tap output equals DEFAULT_TAP (32), and every `lane_fail` bit is 0.
- R2: A run opens with a mode request (`req_op`=0) to address 3 with data 0x04, which sets bit 2 to enable pattern-register access. The last request before `done` is a mode request to address 3 with data 0x00.
- R3: For each tap from 0 to 63 in order, the trainer issues four writes (`req_op`=1) to addresses 0,1,2,3 with data 0x55,0xAA,0x55,0xAA, then four reads (`req_op`=2) to addresses 0,1,2,3. While `busy` is high, every lane's tap output carries the current sweep tap.
- R4: A request held while `req_ready` is low stays valid with unchanged op, address and data. A response is taken only in a cycle where `rsp_ready` and `rsp_valid` are both high.
- R5: Lane i passes a tap only when bit i of all four read words equals the same bit of the written pattern.
- R6: A lane whose passing taps form one contiguous range [first,last] ends with tap floor((first+last)/2) and `lane_fail` low.
- R7: A lane with no passing tap raises `lane_fail` and keeps its previous tap.
- R8: A lane whose passing taps are not contiguous raises `lane_fail` and keeps its previous tap.
- R9: A `start` pulse while `busy` is high is ignored; the current run continues with a single mode-enable request.
- R10: `done` is high for exactly one cycle. From the next cycle, `busy` is low and the tap and fail outputs show the new results. Lane i's tap occupies `lane_tap[6*i+5:6*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a training run (taken only when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| req_valid | output | 1 | Request stream valid |
| req_ready | input | 1 | Request stream ready |
| req_op | output | 2 | 0 mode write, 1 pattern write, 2 pattern read |
| req_addr | output | 2 | Pattern register index, or 3 for the mode register |
| req_data | output | 8 | Write data or mode value |
| rsp_valid | input | 1 | Read response valid |
| rsp_ready | output | 1 | Read response ready |
| rsp_data | input | 8 | Read-back word, bit i from lane i |
| lane_tap | output | 48 | Tap select, 6 bits per lane |
| lane_fail | output | 8 | Per-lane training failure flag |

## Verification
The assertions check every cycle that a stalled request holds still, that the sweep tap only steps by one or returns to zero, that a committed midpoint lies inside the lane's recorded edges, that a failed lane's tap does not move, and that fail flags change only at the end of a run. The bench scenarios cover what the assertions cannot: the request order and pattern values, the midpoint arithmetic against windows placed at both ends of the tap range, the detection of empty and gapped windows, and a `start` pulse in the middle of a run being ignored.

// File: rtl/eye_pkg.sv
package eye_pkg;
  typedef enum logic [1:0] {
    OP_MODE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } req_op_e;

  localparam int NUM_PAT = 4;
  localparam int PAT_AW = 2;
  localparam logic [PAT_AW-1:0] MODE_REG_ADDR = 2'd3;
  localparam int MPR_EN_BIT = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_MODE_ON, S_WR, S_RD_REQ, S_RD_WAIT, S_SHIFT, S_MODE_OFF, S_DONE
  } seq_state_e;
endpackage

// File: rtl/eye_seq.sv
module eye_seq
  import eye_pkg::*;
#(
  parameter int LANES = 8,
  parameter int TAP_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  output logic                  clear,
  output logic                  sample,
  output logic [LANES-1:0]      pass_vec,
  output logic [TAP_W-1:0]      sweep_tap,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [1:0]            req_op,
  output logic [PAT_AW-1:0]     req_addr,
  output logic [LANES-1:0]      req_data,
  input  logic                  rsp_valid,
  output logic                  rsp_ready,
  input  logic [LANES-1:0]      rsp_data
);
  localparam logic [TAP_W-1:0] TAP_LAST = '1;
  localparam logic [PAT_AW-1:0] IDX_LAST = PAT_AW'(NUM_PAT - 1);

  seq_state_e state;
  logic [PAT_AW-1:0] idx;

  function automatic logic [LANES-1:0] pattern(input logic [PAT_AW-1:0] k);
    logic [LANES-1:0] p;
    for (int j = 0; j < LANES; j++) p[j] = ~((j % 2 == 1) ^ k[0]);
    return p;
  endfunction

  always_comb begin
    req_valid = (state == S_MODE_ON) || (state == S_WR) ||
                (state == S_RD_REQ) || (state == S_MODE_OFF);
    req_op    = OP_MODE;
    req_addr  = idx;
    req_data  = '0;
    case (state)
      S_MODE_ON: begin
        req_addr = MODE_REG_ADDR;
        req_data[MPR_EN_BIT] = 1'b1;
      end
      S_WR: begin
        req_op   = OP_WRITE;
        req_data = pattern(idx);
      end
      S_RD_REQ:   req_op = OP_READ;
      S_MODE_OFF: req_addr = MODE_REG_ADDR;
      default: ;
    endcase
  end

  assign rsp_ready = (state == S_RD_WAIT);
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign sample    = (state == S_SHIFT);
  assign clear     = (state == S_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      sweep_tap <= '0;
      pass_vec  <= '1;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state     <= S_MODE_ON;
          sweep_tap <= '0;
        end
        S_MODE_ON: if (req_ready) begin
          state    <= S_WR;
          idx      <= '0;
          pass_vec <= '1;
        end
        S_WR: if (req_ready) begin
          if (idx == IDX_LAST) begin
            idx   <= '0;
            state <= S_RD_REQ;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_RD_REQ: if (req_ready) state <= S_RD_WAIT;
        S_RD_WAIT: if (rsp_valid) begin
          pass_vec <= pass_vec & ~(rsp_data ^ pattern(idx));
          if (idx == IDX_LAST) begin
            state <= S_SHIFT;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_RD_REQ;
          end
        end
        S_SHIFT: begin
          if (sweep_tap == TAP_LAST) begin
            state <= S_MODE_OFF;
          end else begin
            sweep_tap <= sweep_tap + 1'b1;
            idx       <= '0;
            pass_vec  <= '1;
            state     <= S_WR;
          end
        end
        S_MODE_OFF: if (req_ready) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4: a stalled request keeps its content
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_addr) && $stable(req_data))
    else $error("request changed while stalled");

  // R3: sweep tap moves by one step or restarts at zero
  p_tap_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sweep_tap) |-> (sweep_tap == $past(sweep_tap) + 1'b1) || (sweep_tap == '0))
    else $error("sweep tap jumped");
endmodule

// File: rtl/eye_lane.sv
module eye_lane #(
  parameter int TAP_W = 6,
  parameter logic [TAP_W-1:0] DEFAULT_TAP = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample,
  input  logic             pass,
  input  logic [TAP_W-1:0] tap,
  input  logic             commit,
  output logic [TAP_W-1:0] tap_q,
  output logic             fail_q
);
  logic             seen, closed, broken;
  logic [TAP_W-1:0] first, last;
  logic [TAP_W:0]   sum;

  assign sum = {1'b0, first} + {1'b0, last};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen   <= 1'b0;
      closed <= 1'b0;
      broken <= 1'b0;
      first  <= '0;
      last   <= '0;
      tap_q  <= DEFAULT_TAP;
      fail_q <= 1'b0;
    end else begin
      if (clear) begin
        seen   <= 1'b0;
        closed <= 1'b0;
        broken <= 1'b0;
      end else if (sample) begin
        if (pass) begin
          if (!seen) begin
            seen  <= 1'b1;
            first <= tap;
            last  <= tap;
          end else if (closed) begin
            broken <= 1'b1;
          end else begin
            last <= tap;
          end
        end else if (seen) begin
          closed <= 1'b1;
        end
      end
      if (commit) begin
        if (seen && !broken) begin
          tap_q  <= sum[TAP_W:1];
          fail_q <= 1'b0;
        end else begin
          fail_q <= 1'b1;
        end
      end
    end
  end

  // R6: committed tap lies between the recorded edges
  p_mid_inside_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit && seen && !broken |=> (tap_q >= $past(first)) && (tap_q <= $past(last)))
    else $error("midpoint outside window");

  // R7 / R8: a failed lane keeps its tap
  p_fail_keeps_tap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit && (!seen || broken) |=> $stable(tap_q))
    else $error("failed lane tap moved");
endmodule

// File: rtl/eye_trainer.sv
module eye_trainer
  import eye_pkg::*;
#(
  parameter int LANES = 8,
  parameter int TAP_W = 6,
  parameter logic [TAP_W-1:0] DEFAULT_TAP = 6'd32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic [1:0]             req_op,
  output logic [PAT_AW-1:0]      req_addr,
  output logic [LANES-1:0]       req_data,
  input  logic                   rsp_valid,
  output logic                   rsp_ready,
  input  logic [LANES-1:0]       rsp_data,
  output logic [LANES*TAP_W-1:0] lane_tap,
  output logic [LANES-1:0]       lane_fail
);
  logic             clear, sample;
  logic [LANES-1:0] pass_vec;
  logic [TAP_W-1:0] sweep_tap;
  logic [TAP_W-1:0] tap_q [LANES];

  eye_seq #(.LANES(LANES), .TAP_W(TAP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .clear(clear), .sample(sample),
    .pass_vec(pass_vec), .sweep_tap(sweep_tap),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    eye_lane #(.TAP_W(TAP_W), .DEFAULT_TAP(DEFAULT_TAP)) u_lane (
      .clk(clk), .rst_n(rst_n), .clear(clear), .sample(sample),
      .pass(pass_vec[i]), .tap(sweep_tap), .commit(done),
      .tap_q(tap_q[i]), .fail_q(lane_fail[i])
    );
    assign lane_tap[i*TAP_W +: TAP_W] = busy ? sweep_tap : tap_q[i];
  end

  // R10: fail flags only move on the cycle after done
  p_fail_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lane_fail) |-> $past(done))
    else $error("fail flags changed mid-run");
endmodule

// File: tb/tb_eye_trainer.sv
module tb_eye_trainer;
  localparam int LANES = 8;
  localparam int TAP_W = 6;

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, req_valid, req_ready, rsp_valid, rsp_ready;
  logic [1:0] req_op, req_addr;
  logic [LANES-1:0] req_data, rsp_data, lane_fail;
  logic [LANES*TAP_W-1:0] lane_tap;

  always #4 clk = ~clk;

  eye_trainer dut (.*);

  int checks = 0, fails = 0;
  int lo[LANES], hi[LANES], hole[LANES];
  bit none[LANES];
  int exp_tap[LANES];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit lane_pass(input int i, input int t);
    return !none[i] && t >= lo[i] && t <= hi[i] && t != hole[i];
  endfunction

  function automatic logic [7:0] pat(input int k);
    return (k % 2 == 0) ? 8'h55 : 8'hAA;
  endfunction

  // behavioural memory with pattern registers
  logic mode_on;
  logic [7:0] mpr [4];
  int wr_seq, rd_seq, mode_set_cnt, mode_clr_cnt, cyc;
  logic pend; int dly; logic [7:0] pend_data;
  logic prev_stall; logic [1:0] p_op, p_addr; logic [7:0] p_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      mode_on <= 0; pend <= 0; rsp_valid <= 0; rsp_data <= '0;
      req_ready <= 0; prev_stall <= 0; cyc <= 0;
    end else begin
      cyc <= cyc + 1;
      req_ready <= (cyc % 3) != 1;
      if (prev_stall)
        chk(req_valid && req_op == p_op && req_addr == p_addr && req_data == p_data,
            "R4 stalled request held", {req_op, req_addr}, {p_op, p_addr});
      prev_stall <= req_valid && !req_ready;
      p_op <= req_op; p_addr <= req_addr; p_data <= req_data;
      if (rsp_valid && rsp_ready) rsp_valid <= 0;
      if (pend) begin
        if (dly == 0) begin rsp_valid <= 1; rsp_data <= pend_data; pend <= 0; end
        else dly <= dly - 1;
      end
      if (req_valid && req_ready) begin
        case (req_op)
          2'd0: begin
            chk(req_addr == 2'd3, "R2 mode address", req_addr, 3);
            if (req_data == 8'h04) begin mode_on <= 1; mode_set_cnt++; end
            else if (req_data == 8'h00) begin mode_on <= 0; mode_clr_cnt++; end
            else chk(0, "R2 mode value", req_data, 4);
          end
          2'd1: begin
            chk(mode_on && req_addr == wr_seq % 4 && req_data == pat(wr_seq % 4),
                "R3 write order", {req_addr, req_data}, {2'(wr_seq % 4), pat(wr_seq % 4)});
            mpr[req_addr] <= req_data;
            wr_seq++;
          end
          default: begin
            logic [7:0] d;
            bit tap_ok;
            tap_ok = 1;
            for (int i = 0; i < LANES; i++) begin
              if (lane_tap[i*TAP_W +: TAP_W] != 6'(rd_seq / 4)) tap_ok = 0;
              d[i] = lane_pass(i, rd_seq / 4) ? mpr[req_addr][i] : ~mpr[req_addr][i];
            end
            chk(mode_on && req_addr == rd_seq % 4 && req_op == 2'd2, "R3 read order",
                req_addr, rd_seq % 4);
            chk(tap_ok, "R3 sweep tap on all lanes", lane_tap[5:0], rd_seq / 4);
            pend <= 1; dly <= rd_seq % 3; pend_data <= d;
            rd_seq++;
          end
        endcase
      end
    end
  end

  task automatic run(input bit poke, input string tag);
    int n;
    wr_seq = 0; rd_seq = 0; mode_set_cnt = 0; mode_clr_cnt = 0;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    chk(busy == 1, "R3 busy after start", busy, 1);
    if (poke) begin
      repeat (500) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    n = 0;
    while (!done && n < 30000) begin @(negedge clk); n++; end
    if (n >= 30000) chk(0, "watchdog", n, 0);
    @(negedge clk);
    chk(!done && !busy, "R10 done single pulse, idle after", {done, busy}, 0);
    chk(mode_set_cnt == 1, poke ? "R9 one enable per run" : "R2 one enable", mode_set_cnt, 1);
    chk(mode_clr_cnt == 1 && !mode_on, "R2 disable at end", mode_clr_cnt, 1);
    chk(wr_seq == 256 && rd_seq == 256, "R3 request count", wr_seq + rd_seq, 512);
    for (int i = 0; i < LANES; i++) begin
      bit f;
      f = none[i] || (hole[i] > lo[i] && hole[i] < hi[i]);
      if (!f) exp_tap[i] = (lo[i] + hi[i]) / 2;
      chk(lane_fail[i] == f, none[i] ? "R7 fail flag" : (f ? "R8 fail flag" : "R5 lane pass flag"),
          lane_fail[i], f);
      chk(lane_tap[i*TAP_W +: TAP_W] == 6'(exp_tap[i]),
          f ? "R7/R8 tap kept" : "R6 midpoint", lane_tap[i*TAP_W +: TAP_W], exp_tap[i]);
    end
    $display("run %s finished", tag);
  endtask

  task automatic set_lane(input int i, input int l, input int h, input int ho, input bit no);
    lo[i] = l; hi[i] = h; hole[i] = ho; none[i] = no;
  endtask

  initial begin
    for (int i = 0; i < LANES; i++) begin exp_tap[i] = 32; set_lane(i, 0, 0, -1, 1); end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !req_valid, "R1 idle outputs", {busy, done, req_valid}, 0);
    for (int i = 0; i < LANES; i++)
      chk(lane_tap[i*TAP_W +: TAP_W] == 6'd32 && !lane_fail[i], "R1 reset tap",
          lane_tap[i*TAP_W +: TAP_W], 32);

    set_lane(0, 0, 0, -1, 0);   set_lane(1, 0, 63, -1, 0);
    set_lane(2, 63, 63, -1, 0); set_lane(3, 10, 20, -1, 0);
    set_lane(4, 5, 8, -1, 0);   set_lane(5, 30, 45, -1, 0);
    set_lane(6, 1, 2, -1, 0);   set_lane(7, 40, 61, -1, 0);
    run(0, "edges");

    set_lane(0, 0, 0, -1, 1);   set_lane(1, 0, 63, 30, 0);
    set_lane(2, 20, 21, -1, 0); set_lane(3, 33, 60, -1, 0);
    set_lane(4, 7, 7, -1, 0);   set_lane(5, 0, 62, -1, 0);
    set_lane(6, 12, 51, 13, 0); set_lane(7, 0, 0, -1, 1);
    run(0, "failures");

    for (int i = 0; i < LANES; i++) set_lane(i, 17 + i, 20 + 2 * i, -1, 0);
    run(1, "restart ignored");

    for (int i = 0; i < LANES; i++) set_lane(i, 8 * i, 8 * i + 7 - i % 3, 8 * i + 3, i % 2 == 0);
    run(0, "mixed");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule